// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Status Unit

This block holds the interrupt bookkeeping of a real-time clock. Three event pulses come in from logic outside the block: an alarm match, a periodic tick and an update-cycle-ended strobe. Each pulse sets its own sticky flag, whether or not the host has enabled that source. The host reaches the block through a small register bus. It writes a three-bit enable mask, polls or services the flags through a read-to-clear register, and reads a validity status register whose top bit says whether the clock contents can be trusted.

A read of the flag register takes a snapshot of the flags. The next cycle clears only the bits that the read returned as 1. Any event that arrives during the read is held and merged back in when the read completes, so no event is lost and the returned value never changes within a read. The active-low interrupt line is low whenever some source has both its flag and its enable set. If the host enables a source whose flag is already set, the line falls at once.

Flag clearing is handled by a two-state machine. In ST_IDLE events OR into the flags. A flag read moves it to ST_CLEAR (transition CAPTURE), which stores the snapshot and holds that cycle's events. ST_CLEAR always returns to ST_IDLE (transition RELEASE), clearing the snapshot bits and merging the held and new events. The valid-time bit is a second two-state machine. VT_INVALID moves to VT_VALID on a host read of the validity register while the low-battery level is inactive (transition CONFIRM). VT_VALID moves to VT_INVALID whenever the low-battery level is active (transition LOSS). The host must leave at least one idle cycle between two flag reads. A flag read issued in the cycle just after another flag read returns the current flags and clears nothing.

Top module: `rtc_irq_status`

## Requirements
- R1: Each event pulse sets its flag in the cycle after it is seen, whatever its enable bit holds. Flag bits are alarm at bit 0, periodic at bit 1 and update-ended at bit 2.
- R2: `irq_n` is 0 exactly when some source has both its flag and its enable set, and 1 otherwise.
- R3: A write of an enable bit whose flag is already pending drives `irq_n` low in the cycle right after the write.
- R4: A flag read (address 1) returns on `bus_rdata` in the following cycle. Bits 2:0 hold the flags as they were in the read cycle, bit 7 holds the summary (1 when `irq_n` was low in the read cycle) and bits 6:3 are 0.
- R5: One cycle after a flag read, exactly the flag bits returned as 1 are cleared. Other flags keep their value.
- R6: An event arriving in the read cycle or in the cycle after it is absent from the returned value but present in the flags once the read completes.
- R7: The summary bit and `irq_n` return to their idle values after a read that clears every enabled pending flag.
- R8: The validity register (address 2) returns bit 7 as the valid-time bit and bits 6:0 as 0. Writes to it change nothing.
- R9: An active `low_batt` clears the valid-time bit. A host read of the validity register returns the current value and then sets the bit to 1, unless `low_batt` is active.
- R10: Synchronous reset clears all flags and enables, holds `irq_n` at 1, leaves the valid-time bit at 0 and zeroes `bus_rdata`.
- R11: The enable register (address 0) is written from `bus_wdata[2:0]` and reads back in bits 2:0 with the other bits 0. Writes to the flag register have no effect, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_update | input | 1 | Update-cycle-ended pulse |
| low_batt | input | 1 | Low-battery level |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register address: 0 enable, 1 flags, 2 validity |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held until the next read |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Flags are raised with every source disabled, to separate event capture from interrupt signalling. The sources are then enabled after the fact, to expose a line that only reacts to new events. Events are placed in the read cycle and in the clear cycle, to tell a correct snapshot-and-hold from one that loses events or returns torn data. Reads that return partial sets show that clearing is per bit and not a blanket wipe. Validity-register reads with and without low battery, and writes to the read-only registers, separate the valid-bit side effect from any write path. A long stretch of random events, enable writes and reads is compared cycle by cycle against a bench model of the requirements.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NSRC       = 3;
    localparam int SRC_ALARM  = 0;
    localparam int SRC_PERIOD = 1;
    localparam int SRC_UPDATE = 2;

    localparam int REG_ENABLE = 0;
    localparam int REG_FLAGS  = 1;
    localparam int REG_VALID  = 2;

    typedef enum logic {
        ST_IDLE,
        ST_CLEAR
    } clr_state_e;

    typedef enum logic {
        VT_INVALID,
        VT_VALID
    } vt_state_e;

endpackage

// File: rtl/rtc_flag_fsm.sv
module rtc_flag_fsm
    import rtc_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         rd_flags,
    output logic [N-1:0] flags,
    output logic         busy
);

    clr_state_e   state_q, state_nx;
    logic [N-1:0] flags_q, flags_nx;
    logic [N-1:0] snap_q, snap_nx;
    logic [N-1:0] hold_q, hold_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            snap_q  <= '0;
            hold_q  <= '0;
        end else begin
            flags_q <= flags_nx;
            snap_q  <= snap_nx;
            hold_q  <= hold_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        snap_nx  = snap_q;
        hold_nx  = hold_q;
        flags_nx = flags_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_flags) begin
                    snap_nx  = flags_q;
                    hold_nx  = evt;
                    state_nx = ST_CLEAR;
                end else begin
                    flags_nx = flags_q | evt;
                end
            end
            ST_CLEAR: begin
                for (int i = 0; i < N; i++) begin
                    flags_nx[i] = (flags_q[i] & ~snap_q[i]) | hold_q[i] | evt[i];
                end
                hold_nx  = '0;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign flags = flags_q;
    assign busy  = (state_q == ST_CLEAR);

endmodule

// File: rtl/rtc_valid_fsm.sv
module rtc_valid_fsm
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic low_batt,
    input  logic rd_valid,
    output logic valid
);

    vt_state_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VT_INVALID;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            VT_INVALID: if (rd_valid && !low_batt) state_nx = VT_VALID;
            VT_VALID:   if (low_batt)              state_nx = VT_INVALID;
            default:    state_nx = VT_INVALID;
        endcase
    end

    assign valid = (state_q == VT_VALID);

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_alarm,
    input  logic              evt_periodic,
    input  logic              evt_update,
    input  logic              low_batt,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);

    localparam int SUM_BIT = DATA_W - 1;

    logic [NSRC-1:0]   evt_vec;
    logic [NSRC-1:0]   en_q;
    logic [NSRC-1:0]   flags_w;
    logic              busy_w;
    logic              valid_w;
    logic              irq_act;
    logic              rd_flags, rd_valid, wr_enable;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        evt_vec             = '0;
        evt_vec[SRC_ALARM]  = evt_alarm;
        evt_vec[SRC_PERIOD] = evt_periodic;
        evt_vec[SRC_UPDATE] = evt_update;
    end

    assign rd_flags  = bus_rd && (bus_addr == ADDR_W'(REG_FLAGS));
    assign rd_valid  = bus_rd && (bus_addr == ADDR_W'(REG_VALID));
    assign wr_enable = bus_wr && (bus_addr == ADDR_W'(REG_ENABLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_enable) begin
            en_q <= bus_wdata[NSRC-1:0];
        end
    end

    rtc_flag_fsm #(.N(NSRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_vec),
        .rd_flags (rd_flags && !busy_w),
        .flags    (flags_w),
        .busy     (busy_w)
    );

    rtc_valid_fsm u_valid (
        .clk      (clk),
        .rst      (rst),
        .low_batt (low_batt),
        .rd_valid (rd_valid),
        .valid    (valid_w)
    );

    assign irq_act = |(flags_w & en_q);

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(REG_ENABLE): rd_mux[NSRC-1:0] = en_q;
            ADDR_W'(REG_FLAGS): begin
                rd_mux[NSRC-1:0] = flags_w;
                rd_mux[SUM_BIT]  = irq_act;
            end
            ADDR_W'(REG_VALID):  rd_mux[SUM_BIT] = valid_w;
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_n     = ~irq_act;

endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk
    import rtc_irq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       evt_alarm,
    input logic       low_batt,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       irq_n,
    input logic [2:0] flags_w,
    input logic       busy_w,
    input logic       valid_w
);

    AST_RESET_IRQ_HIGH: assert property (@(posedge clk)
        rst |=> irq_n); // R10

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (evt_alarm && !(bus_rd && bus_addr == 2'(REG_FLAGS))) |=> flags_w[SRC_ALARM]); // R1

    AST_HELD_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (evt_alarm && bus_rd && bus_addr == 2'(REG_FLAGS) && !busy_w) |=> ##1 flags_w[SRC_ALARM]); // R6

    AST_SUMMARY_TRACKS_LINE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'(REG_FLAGS)) |=> (bus_rdata[7] == !$past(irq_n))); // R4

    AST_VALID_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'(REG_VALID)) |=> (bus_rdata[6:0] == 7'd0)); // R8

    AST_LOWBATT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        low_batt |=> !valid_w); // R9

endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_alarm (evt_alarm),
    .low_batt  (low_batt),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .flags_w   (flags_w),
    .busy_w    (busy_w),
    .valid_w   (valid_w)
);

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_alarm = 0, evt_periodic = 0, evt_update = 0, low_batt = 0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int nchk = 0;
    int nfail = 0;

    // bench model state
    logic [2:0] m_flags, m_en, m_snap, m_hold;
    logic       m_clr, m_valid;
    logic [7:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_status u_dut (
        .clk(clk), .rst(rst),
        .evt_alarm(evt_alarm), .evt_periodic(evt_periodic), .evt_update(evt_update),
        .low_batt(low_batt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    function automatic logic [7:0] read_value(input logic [1:0] ad);
        case (ad)
            2'd0:    return {5'd0, m_en};
            2'd1:    return {|(m_flags & m_en), 4'd0, m_flags};
            2'd2:    return {m_valid, 7'd0};
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_flags = 0; m_en = 0; m_snap = 0; m_hold = 0;
        m_clr = 0; m_valid = 0; m_rdata = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        evt_alarm = 0; evt_periodic = 0; evt_update = 0; low_batt = 0;
        bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        check({7'd0, irq_n}, 8'd1, "R10");
        check(bus_rdata, 8'd0, "R10");
    endtask

    // One bus cycle: drive at negedge, update model at the edge, compare at next negedge
    task automatic step(input logic [2:0] ev, input logic lb, input logic rd, input logic wr,
                        input logic [1:0] ad, input logic [7:0] wd, input string tag);
        logic [7:0] rv;
        {evt_update, evt_periodic, evt_alarm} = ev;
        low_batt = lb; bus_rd = rd; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
        rv = read_value(ad);
        @(posedge clk);
        if (rd) m_rdata = rv;
        if (m_clr) begin
            m_flags = (m_flags & ~m_snap) | m_hold | ev;
            m_hold = 0;
            m_clr = 0;
        end else if (rd && ad == 2'd1) begin
            m_snap = m_flags;
            m_hold = ev;
            m_clr = 1;
        end else begin
            m_flags = m_flags | ev;
        end
        if (wr && ad == 2'd0) m_en = wd[2:0];
        if (lb) m_valid = 0;
        else if (rd && ad == 2'd2) m_valid = 1;
        @(negedge clk);
        evt_alarm = 0; evt_periodic = 0; evt_update = 0;
        bus_rd = 0; bus_wr = 0;
        check({7'd0, irq_n}, {7'd0, ~|(m_flags & m_en)}, "R2");
        if (rd) check(bus_rdata, m_rdata, tag);
    endtask

    task automatic idle();
        step(3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0, "R2");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic prev_frd;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R10: reset contents of all three registers
        step(0, 0, 1, 0, 2'd1, 0, "R10"); check(bus_rdata, 8'h00, "R10");
        idle();
        step(0, 0, 1, 0, 2'd0, 0, "R10"); check(bus_rdata, 8'h00, "R10");
        step(0, 0, 1, 0, 2'd2, 0, "R10"); check(bus_rdata, 8'h00, "R10");
        // R9: the read above set the valid bit
        step(0, 0, 1, 0, 2'd2, 0, "R9");  check(bus_rdata, 8'h80, "R9");

        // R1: flag set with interrupts disabled, line stays high
        step(3'b001, 0, 0, 0, 0, 0, "R1");
        check({7'd0, irq_n}, 8'd1, "R1");
        step(0, 0, 1, 0, 2'd1, 0, "R1"); check(bus_rdata, 8'h01, "R1");
        idle();
        step(0, 0, 1, 0, 2'd1, 0, "R5"); check(bus_rdata, 8'h00, "R5");
        idle();

        // R3: enable after the event already happened
        step(3'b010, 0, 0, 0, 0, 0, "R1");
        idle();
        step(0, 0, 0, 1, 2'd0, 8'h02, "R3");
        check({7'd0, irq_n}, 8'd0, "R3");
        step(0, 0, 1, 0, 2'd1, 0, "R4"); check(bus_rdata, 8'h82, "R4");
        idle();
        check({7'd0, irq_n}, 8'd1, "R7");
        step(0, 0, 1, 0, 2'd1, 0, "R7"); check(bus_rdata, 8'h00, "R7");
        idle();

        // R5/R6: partial set, event in read cycle and in clear cycle
        step(3'b001, 0, 0, 0, 0, 0, "R1");
        step(3'b100, 0, 1, 0, 2'd1, 0, "R6"); check(bus_rdata, 8'h01, "R6");
        step(3'b010, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 2'd1, 0, "R6"); check(bus_rdata, 8'h86, "R6");
        idle();
        step(0, 0, 1, 0, 2'd1, 0, "R5"); check(bus_rdata, 8'h00, "R5");
        idle();

        // R8: writes to validity register ignored
        step(0, 0, 0, 1, 2'd2, 8'h00, "R8");
        step(0, 0, 1, 0, 2'd2, 0, "R8"); check(bus_rdata, 8'h80, "R8");
        // R9: low battery clears, read returns 0 then re-validates
        step(0, 1, 0, 0, 0, 0, "R9");
        step(0, 1, 1, 0, 2'd2, 0, "R9"); check(bus_rdata, 8'h00, "R9");
        step(0, 0, 1, 0, 2'd2, 0, "R9"); check(bus_rdata, 8'h00, "R9");
        step(0, 0, 1, 0, 2'd2, 0, "R9"); check(bus_rdata, 8'h80, "R9");

        // R11: flag register writes ignored, enable readback, address 3
        step(0, 0, 0, 1, 2'd1, 8'hFF, "R11");
        step(0, 0, 1, 0, 2'd1, 0, "R11"); check(bus_rdata, 8'h00, "R11");
        idle();
        step(0, 0, 0, 1, 2'd0, 8'hFD, "R11");
        step(0, 0, 1, 0, 2'd0, 0, "R11"); check(bus_rdata, 8'h05, "R11");
        step(0, 0, 1, 0, 2'd3, 0, "R11"); check(bus_rdata, 8'h00, "R11");

        // Random phase against the bench model
        prev_frd = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] ev;
            logic       lb, rd, wr;
            logic [1:0] ad;
            logic [7:0] wd;
            string      tg;
            ev[0] = ($urandom % 8) == 0;
            ev[1] = ($urandom % 10) == 0;
            ev[2] = ($urandom % 12) == 0;
            lb = ($urandom % 50) == 0;
            ad = 2'($urandom % 4);
            rd = ($urandom % 3) == 0;
            wr = !rd && (($urandom % 6) == 0);
            wd = 8'($urandom);
            if (prev_frd && ad == 2'd1) rd = 0;
            tg = (ad == 2'd1) ? "R5" : (ad == 2'd0) ? "R11" : "R8";
            step(ev, lb, rd, wr, ad, wd, tg);
            prev_frd = rd && ad == 2'd1;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule